// File: doc/BRIEF.md
# Commit Thread Selector

In a multithreaded out-of-order core, each commit slot must be given to one hardware thread. This block makes that choice. For every thread it takes a status code, a flag that the head of the reorder buffer is ready, a flag that the buffer is empty, and the sequence number of the head instruction. From these it returns a valid flag and the index of the chosen thread. The output is combinational, so the selector can be consulted once for each commit slot.

A static policy input selects one of three rules:

- **Greedy.** Picks the oldest ready head, and may be used for every slot of a cycle.
- **Rotating.** Keeps an internal ordered list of threads. It grants the first eligible thread in the list and then sends that thread to the back of the list.
- **Oldest-first.** Compares head sequence numbers and picks the smallest.

A select strobe from the commit logic tells the rotating list that a grant was consumed. Buffer contents, retirement and squash handling belong to the surrounding stage.

Top module: `commit_thread_picker`

## Requirements
- R1: A thread is eligible only when all of these hold: its 3-bit status is 0 (running), 1 (idle) or 4 (fetch trap waiting), its head-ready bit is 1, and its empty bit is 0. Status 2 (squashing) and status 3 (trap waiting) are never granted.
- R2: With cfg_policy 2'b10 (oldest-first), or with the reserved code 2'b11 that acts the same way, the grant goes to the eligible thread whose head sequence number is smallest. Numbers are compared as unsigned values of full width, with no wraparound.
- R3: With cfg_policy 2'b00 (greedy), the selection is the same as with oldest-first.
- R4: Under oldest-first and greedy, equal sequence numbers resolve to the lowest thread index.
- R5: When no thread is eligible, grant_valid is 0 and grant_tid is 0.
- R6: With cfg_policy 2'b01 (rotating), the grant goes to the first eligible thread found by scanning the priority list from its front.
- R7: A clock edge with sel_strobe high, rotating policy and grant_valid high moves the granted thread to the back of the list. The other threads keep their relative order.
- R8: The list does not change when sel_strobe comes without a grant, or when sel_strobe comes under any policy other than rotating.
- R9: After reset, the list holds the thread indices in ascending order, 0 first.
- R10: When NUM_THREADS is 1, thread 0 is granted exactly when its status is eligible. The ready bit, the empty bit and the policy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the priority list |
| cfg_policy | input | 2 | Policy: 00 greedy, 01 rotating, 10/11 oldest-first |
| thr_status | input | 3*NUM_THREADS | Per-thread status code; thread i at bits [3i+2:3i] |
| thr_head_ready | input | NUM_THREADS | Head instruction ready, one bit per thread |
| thr_rob_empty | input | NUM_THREADS | Reorder buffer empty, one bit per thread |
| thr_head_seq | input | SEQ_W*NUM_THREADS | Head sequence number; thread i at bits [SEQ_W*i +: SEQ_W] |
| sel_strobe | input | 1 | The current grant is consumed this cycle |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TID_W | Granted thread index, 0 when no grant |

## Verification
The rotating tests grant each thread and then make one thread ineligible. They check that the skipped thread stays at the front and that only the winner moves back. A design that moves every passed-over thread back, or that rotates by a fixed step, returns the wrong index on the following grant.

Strobes are also issued while no thread is eligible, and while the oldest-first policy is active. A list that advances on those strobes shows up as a shifted grant once rotating resumes.

Sequence numbers near the top of the unsigned range expose a comparison done with wraparound. Equal numbers expose a tie-break that favours the higher index. A further check confirms that a reset in the middle of a run restores the ascending order.

// File: rtl/csel_pkg.sv
package csel_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_RUNNING = 3'd0,
      ST_IDLE    = 3'd1,
      ST_SQUASH  = 3'd2,
      ST_TRAP    = 3'd3,
      ST_FTRAP   = 3'd4
   } thr_state_e;

   typedef enum logic [1:0] {
      POL_GREEDY = 2'd0,
      POL_ROTATE = 2'd1,
      POL_OLDEST = 2'd2,
      POL_OLDEST_ALT = 2'd3
   } pol_e;

   // status codes that allow a thread to retire
   function automatic logic state_ok(input logic [STATE_W-1:0] s);
      return (s == ST_RUNNING) || (s == ST_IDLE) || (s == ST_FTRAP);
   endfunction

endpackage

// File: rtl/csel_elig.sv
module csel_elig
   import csel_pkg::*;
#(
   parameter int NUM_THREADS = 4
) (
   input  logic [STATE_W*NUM_THREADS-1:0] thr_status,
   input  logic [NUM_THREADS-1:0]         thr_head_ready,
   input  logic [NUM_THREADS-1:0]         thr_rob_empty,
   output logic [NUM_THREADS-1:0]         elig
);

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         assign elig[t] = state_ok(thr_status[STATE_W*t +: STATE_W])
                          & thr_head_ready[t] & ~thr_rob_empty[t];
      end
   endgenerate

endmodule

// File: rtl/csel_rr_list.sv
module csel_rr_list #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] elig,
   input  logic                   advance_en,
   output logic                   pick_valid,
   output logic [TID_W-1:0]       pick_tid
);

   logic [NUM_THREADS-1:0][TID_W-1:0] order_q, order_d;
   logic [TID_W-1:0]                  pick_pos;
   logic [NUM_THREADS-1:0]            present;

   // scan from the front, first eligible entry wins
   always_comb begin
      pick_valid = 1'b0;
      pick_tid   = '0;
      pick_pos   = '0;
      for (int p = 0; p < NUM_THREADS; p++) begin
         if (!pick_valid && elig[order_q[p]]) begin
            pick_valid = 1'b1;
            pick_tid   = order_q[p];
            pick_pos   = TID_W'(p);
         end
      end
   end

   // winner leaves its slot, later entries close the gap, winner goes last
   always_comb begin
      order_d = order_q;
      if (advance_en && pick_valid) begin
         for (int p = 0; p < NUM_THREADS-1; p++) begin
            if (p >= int'(pick_pos))
               order_d[p] = order_q[p+1];
         end
         order_d[NUM_THREADS-1] = pick_tid;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_THREADS; p++)
            order_q[p] <= TID_W'(p);
      end else begin
         order_q <= order_d;
      end
   end

   always_comb begin
      present = '0;
      for (int p = 0; p < NUM_THREADS; p++)
         present[order_q[p]] = 1'b1;
   end

   AST_RR_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(present) == NUM_THREADS); // R7

   AST_RR_WINNER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_en && pick_valid) |=> (order_q[NUM_THREADS-1] == $past(pick_tid))); // R7

   AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(advance_en && pick_valid) |=> $stable(order_q)); // R8

   AST_RR_PICK_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> elig[pick_tid]); // R6

endmodule

// File: rtl/csel_oldest.sv
module csel_oldest #(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 32,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS-1:0]       elig,
   input  logic [SEQ_W*NUM_THREADS-1:0] seq,
   output logic                         pick_valid,
   output logic [TID_W-1:0]             pick_tid
);

   logic [SEQ_W-1:0] best;

   // strict less-than keeps the lower index on a tie
   always_comb begin
      pick_valid = 1'b0;
      pick_tid   = '0;
      best       = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (elig[i] && (!pick_valid || (seq[SEQ_W*i +: SEQ_W] < best))) begin
            pick_valid = 1'b1;
            pick_tid   = TID_W'(i);
            best       = seq[SEQ_W*i +: SEQ_W];
         end
      end
   end

endmodule

// File: rtl/commit_thread_picker.sv
module commit_thread_picker
   import csel_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 32,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     cfg_policy,
   input  logic [STATE_W*NUM_THREADS-1:0] thr_status,
   input  logic [NUM_THREADS-1:0]         thr_head_ready,
   input  logic [NUM_THREADS-1:0]         thr_rob_empty,
   input  logic [SEQ_W*NUM_THREADS-1:0]   thr_head_seq,
   input  logic                           sel_strobe,
   output logic                           grant_valid,
   output logic [TID_W-1:0]               grant_tid
);

   generate
      if (NUM_THREADS < 1) begin : g_bad_threads
         $error("NUM_THREADS must be at least 1");
      end
      if (SEQ_W < 1) begin : g_bad_seq
         $error("SEQ_W must be at least 1");
      end

      if (NUM_THREADS == 1) begin : g_single
         // one thread: status alone decides
         assign grant_valid = state_ok(thr_status[STATE_W-1:0]);
         assign grant_tid   = '0;

         AST_SINGLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid == (thr_status[STATE_W-1:0] inside {ST_RUNNING, ST_IDLE, ST_FTRAP})); // R10
      end else begin : g_multi
         logic [NUM_THREADS-1:0] elig;
         logic                   rr_valid, old_valid;
         logic [TID_W-1:0]       rr_tid, old_tid;
         logic                   rotate_sel;
         logic                   older_exists;
         logic [SEQ_W-1:0]       grant_seq;

         assign rotate_sel = (cfg_policy == POL_ROTATE);

         csel_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
            .thr_status     (thr_status),
            .thr_head_ready (thr_head_ready),
            .thr_rob_empty  (thr_rob_empty),
            .elig           (elig)
         );

         csel_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
            .clk        (clk),
            .rst_n      (rst_n),
            .elig       (elig),
            .advance_en (sel_strobe && rotate_sel),
            .pick_valid (rr_valid),
            .pick_tid   (rr_tid)
         );

         csel_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_old (
            .elig       (elig),
            .seq        (thr_head_seq),
            .pick_valid (old_valid),
            .pick_tid   (old_tid)
         );

         assign grant_valid = rotate_sel ? rr_valid : old_valid;
         assign grant_tid   = rotate_sel ? rr_tid   : old_tid;

         // checker-side view of the age ordering, from the ports
         assign grant_seq = thr_head_seq[SEQ_W*grant_tid +: SEQ_W];
         always_comb begin
            older_exists = 1'b0;
            for (int i = 0; i < NUM_THREADS; i++) begin
               if (state_ok(thr_status[STATE_W*i +: STATE_W]) && thr_head_ready[i]
                   && !thr_rob_empty[i]
                   && ((thr_head_seq[SEQ_W*i +: SEQ_W] < grant_seq)
                       || ((thr_head_seq[SEQ_W*i +: SEQ_W] == grant_seq)
                           && (i < int'(grant_tid)))))
                  older_exists = 1'b1;
            end
         end

         AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid |-> (thr_head_ready[grant_tid] && !thr_rob_empty[grant_tid]
               && thr_status[STATE_W*grant_tid +: STATE_W] inside {ST_RUNNING, ST_IDLE, ST_FTRAP})); // R1

         AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !grant_valid |-> (grant_tid == '0)); // R5

         AST_VALID_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid == (|elig)); // R5

         AST_OLDEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && !rotate_sel) |-> !older_exists); // R2
      end
   endgenerate

endmodule

// File: tb/commit_thread_picker_test.sv
module commit_thread_picker_test;

   localparam int N = 4;
   localparam int NV = 9;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic [1:0]      cfg_policy;
   logic [3*N-1:0]  thr_status;
   logic [N-1:0]    thr_head_ready, thr_rob_empty;
   logic [32*N-1:0] thr_head_seq;
   logic            sel_strobe;
   logic            grant_valid;
   logic [1:0]      grant_tid;

   logic [2:0]  s1_status;
   logic [0:0]  s1_ready, s1_empty;
   logic [31:0] s1_seq;
   logic        s1_valid;
   logic [0:0]  s1_tid;

   int errors = 0;
   int checks = 0;

   commit_thread_picker #(.NUM_THREADS(N), .SEQ_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .thr_status(thr_status),
      .thr_head_ready(thr_head_ready), .thr_rob_empty(thr_rob_empty),
      .thr_head_seq(thr_head_seq), .sel_strobe(sel_strobe),
      .grant_valid(grant_valid), .grant_tid(grant_tid)
   );

   commit_thread_picker #(.NUM_THREADS(1), .SEQ_W(32)) uut_single (
      .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .thr_status(s1_status),
      .thr_head_ready(s1_ready), .thr_rob_empty(s1_empty),
      .thr_head_seq(s1_seq), .sel_strobe(sel_strobe),
      .grant_valid(s1_valid), .grant_tid(s1_tid)
   );

   // status codes: 0 running, 1 idle, 2 squashing, 3 trap waiting, 4 fetch trap waiting
   localparam logic [1:0]  V_POL   [NV] = '{2'd2, 2'd0, 2'd2, 2'd2, 2'd2, 2'd2, 2'd3, 2'd0, 2'd2};
   localparam logic [11:0] V_STAT  [NV] = '{12'h000, 12'h080, 12'h003, 12'h924, 12'h249,
                                            12'h000, 12'h000, 12'h492, 12'h000};
   localparam logic [3:0]  V_RDY   [NV] = '{4'hF, 4'hF, 4'hF, 4'hA, 4'h8, 4'h0, 4'hF, 4'hF, 4'hF};
   localparam logic [3:0]  V_EMP   [NV] = '{4'h0, 4'h0, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
   // head sequence bytes, thread 3 in the top byte
   localparam logic [31:0] V_SEQ   [NV] = '{32'h280A1E14, 32'h280A1E14, 32'h280A1E14, 32'h280A1E14,
                                            32'h280A1E14, 32'h280A1E14, 32'h05050505, 32'h280A1E14,
                                            32'h07090709};
   localparam logic        V_EV    [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic [1:0]  V_ET    [NV] = '{2'd2, 2'd0, 2'd1, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd1};

   function automatic string vec_req(input int k);
      case (k)
         0: return "R2 oldest";
         1: return "R3 greedy skips squashing";
         2: return "R1 trap and empty excluded";
         3: return "R1 fetch-trap status with partial ready";
         4: return "R1 idle status";
         5: return "R5 nothing ready";
         6: return "R4 tie to lowest, reserved code";
         7: return "R1 all squashing";
         default: return "R4 tie among subset";
      endcase
   endfunction

   task automatic check(input string req, input logic av, input logic [1:0] at,
                        input logic ev, input logic [1:0] et);
      checks++;
      if (av !== ev || at !== et) begin
         errors++;
         $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                  req, av, at, ev, et);
      end
   endtask

   task automatic all_ready(input logic [1:0] pol);
      cfg_policy     = pol;
      thr_status     = '0;
      thr_head_ready = '1;
      thr_rob_empty  = '0;
   endtask

   task automatic rr_grant(input logic [1:0] exp_tid, input string req);
      @(negedge clk);
      #1 check(req, grant_valid, grant_tid, 1'b1, exp_tid);
      sel_strobe = 1'b1;
      @(negedge clk);
      sel_strobe = 1'b0;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      sel_strobe = 1'b0;
      all_ready(2'd1);
      thr_head_seq = '0;
      s1_status = 3'd0; s1_ready = 1'b0; s1_empty = 1'b1; s1_seq = '0;
      repeat (3) @(negedge clk);
      // R9: list after reset starts at thread 0
      #1 check("R9 reset order", grant_valid, grant_tid, 1'b1, 2'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         cfg_policy     = V_POL[k];
         thr_status     = V_STAT[k];
         thr_head_ready = V_RDY[k];
         thr_rob_empty  = V_EMP[k];
         for (int i = 0; i < N; i++)
            thr_head_seq[32*i +: 32] = {24'd0, V_SEQ[k][8*i +: 8]};
         #1 check(vec_req(k), grant_valid, grant_tid, V_EV[k], V_ET[k]);
      end

      // R2: full-width unsigned compare, no wrap
      @(negedge clk);
      all_ready(2'd2);
      thr_head_seq = {32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFF0};
      #1 check("R2 wide sequence", grant_valid, grant_tid, 1'b1, 2'd1);

      // rotating policy from the reset order
      all_ready(2'd1);
      rr_grant(2'd0, "R6 first of list");
      rr_grant(2'd1, "R7 rotate");
      rr_grant(2'd2, "R7 rotate");
      rr_grant(2'd3, "R7 rotate");
      rr_grant(2'd0, "R7 wrap"); // list now 1,2,3,0

      // R8: strobe with nothing eligible
      @(negedge clk);
      thr_head_ready = '0;
      #1 check("R5 rotating none", grant_valid, grant_tid, 1'b0, 2'd0);
      sel_strobe = 1'b1;
      @(negedge clk);
      sel_strobe = 1'b0;
      thr_head_ready = '1;
      #1 check("R8 no grant no move", grant_valid, grant_tid, 1'b1, 2'd1);

      // R8: strobe under oldest-first does not rotate
      @(negedge clk);
      cfg_policy = 2'd2;
      sel_strobe = 1'b1;
      @(negedge clk);
      sel_strobe = 1'b0;
      cfg_policy = 2'd1;
      #1 check("R8 other policy no move", grant_valid, grant_tid, 1'b1, 2'd1);

      // skip squashing thread 1: only the winner moves back
      thr_status[5:3] = 3'd2;
      rr_grant(2'd2, "R6 skip ineligible");   // list 1,3,0,2
      thr_status[5:3] = 3'd0;
      rr_grant(2'd1, "R7 skipped stays front"); // list 3,0,2,1
      rr_grant(2'd3, "R7 order kept");
      rr_grant(2'd0, "R7 order kept");
      rr_grant(2'd2, "R7 order kept");
      rr_grant(2'd1, "R7 order kept");

      // R9: reset mid-run restores ascending order
      rr_grant(2'd3, "R7 before reset");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R9 reset restores", grant_valid, grant_tid, 1'b1, 2'd0);

      // R10: single-thread variant
      s1_status = 3'd0; s1_ready = 1'b0; s1_empty = 1'b1;
      #1 check("R10 running ignores ready", s1_valid, {1'b0, s1_tid}, 1'b1, 2'd0);
      s1_status = 3'd2;
      #1 check("R10 squashing", s1_valid, {1'b0, s1_tid}, 1'b0, 2'd0);
      s1_status = 3'd4; s1_ready = 1'b1; s1_empty = 1'b0;
      #1 check("R10 fetch trap", s1_valid, {1'b0, s1_tid}, 1'b1, 2'd0);
      s1_status = 3'd3;
      #1 check("R10 trap waiting", s1_valid, {1'b0, s1_tid}, 1'b0, 2'd0);

      finish_run();
   end

endmodule